// File: doc/BRIEF.md
# Byte-Mapped Real-Time Clock Register Bank

This block sits in the sixteen highest byte addresses of a byte-addressed memory space. It keeps a calendar in BCD: seconds, minutes, hours, day of week, date, month, year and century. The time advances once for each single-cycle pulse on a one-per-second tick input. Software reads and writes the bank over a simple synchronous bus, just as it would ordinary memory. Read data comes back one cycle after the request. A control byte gives software two ways to get a consistent view of the time. One is a freeze bit that makes reads return a snapshot. The other is a hold bit that stops the clock so the time bytes can be written, and the new time takes effect when the hold is released.

Alongside the calendar the block provides two supervision features. An alarm compares five fields against month, date, hours, minutes and seconds, and any field can be masked out to get repeating alarms. A watchdog counts down from a programmed setting and is restarted by edges on a kick input. When it expires it raises either a reset pulse or the interrupt line, as its steering bit selects. Both features report through a shared flags byte, and reading that byte clears both flags. While the supply-good input is low, every write is ignored but the time keeps running.

Top module: `timekeep_bank`

## Requirements
- R1: An access hits the bank only when every address bit above bit 3 is 1, and the low four bits select the offset. A read returns its byte on `rdata` one cycle later, with `bank_hit` high. A missed read returns 0 with `bank_hit` low.
- R2: Each `sec_tick` pulse advances the time by one second in BCD, with seconds and minutes wrapping 59→00 and hours wrapping 23→00. The offsets are 9 for seconds, 10 for minutes, 11 for hours, 12 for day of week (01..07) and 13 for date.
- R3: The date (offset 13) wraps according to the month length (offset 14), with February at 29 days when the year (offset 15) is divisible by four. Month 12 wraps to 01 and advances the year. Year 99→00 advances the century at offset 1, which wraps from 99 to 00.
- R4: Control byte offset 8, bit 7 is the hold bit. While it is set, ticks are ignored and writes to offsets 9..15 update a holding copy, which reads return. Clearing the bit loads that copy into the clock. With the bit clear, writes to offsets 9..15 are ignored.
- R5: Control bit 6 is the freeze bit. Setting it captures the time, and reads of offsets 9..15 return that capture until the bit is cleared, while the clock keeps counting.
- R6: Alarm bytes sit at offset 2 (seconds), 3 (minutes), 4 (hours), 5 (date) and 6 (month). On each second update in which every field with bit 7 clear equals the new time in bits 6:0, flags bit 6 is set. A field with bit 7 set always matches. Reset values never match.
- R7: The flags byte (offset 0) holds the watchdog-expired flag in bit 7, the alarm flag in bit 6 and battery-low in bit 4, with all other bits 0. It is also driven on `flag_bits`. Reading offset 0 clears bits 7 and 6. `irq` is high while the alarm flag is set or a watchdog expiry steered to the interrupt is pending.
- R8: Watchdog byte offset 7 holds a count in bits 6:0, in units of `WD_UNIT_CYCLES` clocks, and the steering bit in bit 7. Writing the byte, or any edge on `wdi`, restarts the count. Expiry comes N units after the last restart. A count of 0 disables the watchdog.
- R9: On expiry, flags bit 7 is set. With steering 0, `wd_rst` goes high for exactly `WD_RST_CYCLES` cycles and `irq` is not raised. With steering 1, `irq` is raised and `wd_rst` stays low.
- R10: While `pwr_ok` is low, writes to every offset are ignored, and the time still advances on ticks.
- R11: After reset the time is 00:00:00, day 01, date 01, month 01, year 00, century 00, and the control, watchdog and alarm bytes are 0. Flags bit 4 follows `bat_low`, and reading the flags does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Bus access request this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, one cycle after the request |
| bank_hit | output | 1 | Read data comes from the bank |
| sec_tick | input | 1 | One-cycle pulse per second |
| pwr_ok | input | 1 | Supply in tolerance; low blocks writes |
| bat_low | input | 1 | Battery low indication |
| wdi | input | 1 | Watchdog kick, either edge restarts |
| irq | output | 1 | Interrupt line |
| wd_rst | output | 1 | Reset pulse on steered watchdog expiry |
| flag_bits | output | 8 | Flags byte |

## Verification
Random valid calendar times are loaded, many of them placed just before a seconds, minute, day or year boundary, and advanced by a few ticks. Each result is compared with a bench calendar model, which separates the carry into each field from the plain BCD digit step. Directed cases cover the leap and non-leap ends of February, the ends of 30-day months and the century roll. Alarm runs set one field to match, one field to mismatch, and every field masked, so that mask handling is told apart from the comparison itself. Watchdog runs compare three cases: kicked regularly, left to expire under each steering value, and disabled by a count of zero. Together they show the restart, the expiry timing and the routing to `wd_rst` or `irq`.

// File: rtl/tk_pkg.sv
package tk_pkg;
  localparam int NUM_TIME = 7;
  localparam int NUM_ALM  = 5;
  localparam logic [3:0] OFF_FLAGS = 4'd0;
  localparam logic [3:0] OFF_CENT  = 4'd1;
  localparam logic [3:0] OFF_ALM0  = 4'd2;
  localparam logic [3:0] OFF_WDOG  = 4'd7;
  localparam logic [3:0] OFF_CTRL  = 4'd8;
  localparam logic [3:0] OFF_TIME0 = 4'd9;

  // field k sits at bits [8k +: 8]: sec, min, hour, wday, date, month, year
  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] date;
    logic [7:0] wday;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } tk_time_t;

  localparam tk_time_t TIME_RESET = '{year: 8'h00, month: 8'h01, date: 8'h01,
                                      wday: 8'h01, hour: 8'h00, min: 8'h00, sec: 8'h00};

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] last_date(input logic [7:0] month, input logic [7:0] year);
    logic [6:0] ybin;
    ybin = 7'(year[7:4]) * 7'd10 + 7'(year[3:0]);
    case (month)
      8'h02:                      return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/tk_clock.sv
module tk_clock
  import tk_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     hold,
  input  logic     load,
  input  tk_time_t load_val,
  output tk_time_t now,
  output logic     year_wrap
);
  tk_time_t nxt;
  logic     wrap_c;

  always_comb begin
    nxt    = now;
    wrap_c = 1'b0;
    if (now.sec != 8'h59) nxt.sec = bcd_inc(now.sec);
    else begin
      nxt.sec = 8'h00;
      if (now.min != 8'h59) nxt.min = bcd_inc(now.min);
      else begin
        nxt.min = 8'h00;
        if (now.hour != 8'h23) nxt.hour = bcd_inc(now.hour);
        else begin
          nxt.hour = 8'h00;
          nxt.wday = (now.wday == 8'h07) ? 8'h01 : bcd_inc(now.wday);
          if (now.date != last_date(now.month, now.year)) nxt.date = bcd_inc(now.date);
          else begin
            nxt.date = 8'h01;
            if (now.month != 8'h12) nxt.month = bcd_inc(now.month);
            else begin
              nxt.month = 8'h01;
              if (now.year != 8'h99) nxt.year = bcd_inc(now.year);
              else begin
                nxt.year = 8'h00;
                wrap_c   = 1'b1;
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      now       <= TIME_RESET;
      year_wrap <= 1'b0;
    end else begin
      year_wrap <= 1'b0;
      if (load) now <= load_val;
      else if (tick && !hold) begin
        now       <= nxt;
        year_wrap <= wrap_c;
      end
    end
  end
endmodule

// File: rtl/tk_alarm.sv
module tk_alarm
  import tk_pkg::*;
(
  input  logic [NUM_ALM-1:0][7:0] alm,
  input  logic [NUM_ALM-1:0][7:0] cur,
  output logic                    all_match
);
  logic [NUM_ALM-1:0] fmatch;

  for (genvar i = 0; i < NUM_ALM; i++) begin : g_field
    assign fmatch[i] = alm[i][7] || (alm[i][6:0] == cur[i][6:0]);
  end

  assign all_match = &fmatch;
endmodule

// File: rtl/tk_watchdog.sv
module tk_watchdog #(
  parameter int UNIT_CYCLES = 256,
  parameter int RST_CYCLES  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [6:0] count_in,
  input  logic       reload,
  output logic       timeout,
  output logic       steer_q,
  output logic       rst_out,
  input  logic       steer_in
);
  localparam int PRE_W = (UNIT_CYCLES > 1) ? $clog2(UNIT_CYCLES) : 1;
  localparam int RC_W  = $clog2(RST_CYCLES + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(UNIT_CYCLES - 1);

  logic [PRE_W-1:0] pre_q;
  logic [6:0]       cnt_q;
  logic             armed_q;
  logic [RC_W-1:0]  rcnt_q;
  logic             unit_done;

  assign unit_done = (pre_q == PRE_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q   <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      timeout <= 1'b0;
      steer_q <= 1'b0;
      rcnt_q  <= '0;
    end else begin
      timeout <= 1'b0;
      if (rcnt_q != '0) rcnt_q <= rcnt_q - 1'b1;
      if (reload) begin
        pre_q   <= '0;
        cnt_q   <= count_in;
        armed_q <= (count_in != 7'd0);
        steer_q <= steer_in;
      end else if (armed_q) begin
        pre_q <= unit_done ? '0 : pre_q + 1'b1;
        if (unit_done) begin
          if (cnt_q == 7'd1) begin
            armed_q <= 1'b0;
            timeout <= 1'b1;
            if (!steer_q) rcnt_q <= RC_W'(RST_CYCLES);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      end
    end
  end

  assign rst_out = (rcnt_q != '0);
endmodule

// File: rtl/timekeep_bank.sv
module timekeep_bank
  import tk_pkg::*;
#(
  parameter int ADDR_W         = 19,
  parameter int WD_UNIT_CYCLES = 256,
  parameter int WD_RST_CYCLES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              bank_hit,
  input  logic              sec_tick,
  input  logic              pwr_ok,
  input  logic              bat_low,
  input  logic              wdi,
  output logic              irq,
  output logic              wd_rst,
  output logic [7:0]        flag_bits
);
  localparam int OFF_W = 4;

  logic             hit_c, wr, rd;
  logic [OFF_W-1:0] off;
  logic [7:0]       ctrl_q, wd_set_q, cent_q;
  logic [NUM_ALM-1:0][7:0] alm_q;
  logic             af_q, wdf_q, wdirq_q, bat_q, tick_d;
  logic [2:0]       wdi_sync;
  tk_time_t         now_t, shadow_q, snap_q, view;
  logic             load_p, w_rise, r_rise, hold_q, year_wrap, all_match;
  logic             wd_timeout, wd_steer, wd_reload, wd_wr;
  logic [7:0]       wd_new;

  assign hit_c  = sel && (&addr[ADDR_W-1:OFF_W]);
  assign off    = addr[OFF_W-1:0];
  assign wr     = hit_c && we && pwr_ok;
  assign rd     = hit_c && !we;
  assign hold_q = ctrl_q[7];
  assign load_p = wr && (off == OFF_CTRL) && !wdata[7] && ctrl_q[7];
  assign w_rise = wr && (off == OFF_CTRL) && wdata[7] && !ctrl_q[7];
  assign r_rise = wr && (off == OFF_CTRL) && wdata[6] && !ctrl_q[6];

  tk_clock u_clock (
    .clk      (clk),
    .rst      (rst),
    .tick     (sec_tick),
    .hold     (hold_q),
    .load     (load_p),
    .load_val (shadow_q),
    .now      (now_t),
    .year_wrap(year_wrap)
  );

  tk_alarm u_alarm (
    .alm      (alm_q),
    .cur      ({now_t.month, now_t.date, now_t.hour, now_t.min, now_t.sec}),
    .all_match(all_match)
  );

  assign wd_wr     = wr && (off == OFF_WDOG);
  assign wd_new    = wd_wr ? wdata : wd_set_q;
  assign wd_reload = wd_wr || (wdi_sync[2] ^ wdi_sync[1]);

  tk_watchdog #(
    .UNIT_CYCLES(WD_UNIT_CYCLES),
    .RST_CYCLES (WD_RST_CYCLES)
  ) u_wdog (
    .clk     (clk),
    .rst     (rst),
    .count_in(wd_new[6:0]),
    .reload  (wd_reload),
    .timeout (wd_timeout),
    .steer_q (wd_steer),
    .rst_out (wd_rst),
    .steer_in(wd_new[7])
  );

  // configuration and holding registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      wd_set_q <= '0;
      cent_q   <= '0;
      alm_q    <= '0;
      shadow_q <= TIME_RESET;
      snap_q   <= TIME_RESET;
      wdi_sync <= '0;
    end else begin
      wdi_sync <= {wdi_sync[1:0], wdi};
      if (wr && off == OFF_CTRL) ctrl_q <= wdata;
      if (wd_wr) wd_set_q <= wdata;
      for (int i = 0; i < NUM_ALM; i++)
        if (wr && off == OFF_ALM0 + 4'(i)) alm_q[i] <= wdata;
      if (wr && off == OFF_CENT) cent_q <= wdata;
      else if (year_wrap) cent_q <= (cent_q == 8'h99) ? 8'h00 : bcd_inc(cent_q);
      if (r_rise) snap_q <= now_t;
      if (w_rise) shadow_q <= now_t;
      else if (wr && ctrl_q[7]) begin
        for (int k = 0; k < NUM_TIME; k++)
          if (off == OFF_TIME0 + 4'(k)) shadow_q[8*k +: 8] <= wdata;
      end
    end
  end

  // flags and interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      af_q    <= 1'b0;
      wdf_q   <= 1'b0;
      wdirq_q <= 1'b0;
      bat_q   <= 1'b0;
      tick_d  <= 1'b0;
      irq     <= 1'b0;
    end else begin
      tick_d <= sec_tick && !hold_q && !load_p;
      bat_q  <= bat_low;
      irq    <= af_q || wdirq_q;
      if (tick_d && all_match) af_q <= 1'b1;
      else if (rd && off == OFF_FLAGS) af_q <= 1'b0;
      if (wd_timeout) begin
        wdf_q <= 1'b1;
        if (wd_steer) wdirq_q <= 1'b1;
      end else if (rd && off == OFF_FLAGS) begin
        wdf_q   <= 1'b0;
        wdirq_q <= 1'b0;
      end
    end
  end

  assign flag_bits = {wdf_q, af_q, 1'b0, bat_q, 4'b0000};
  assign view      = ctrl_q[6] ? snap_q : (ctrl_q[7] ? shadow_q : now_t);

  // read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      bank_hit <= 1'b0;
    end else begin
      bank_hit <= rd;
      rdata    <= '0;
      if (rd) begin
        if (off == OFF_FLAGS) rdata <= flag_bits;
        else if (off == OFF_CENT) rdata <= cent_q;
        else if (off == OFF_WDOG) rdata <= wd_set_q;
        else if (off == OFF_CTRL) rdata <= ctrl_q;
        else begin
          for (int i = 0; i < NUM_ALM; i++)
            if (off == OFF_ALM0 + 4'(i)) rdata <= alm_q[i];
          for (int k = 0; k < NUM_TIME; k++)
            if (off == OFF_TIME0 + 4'(k)) rdata <= view[8*k +: 8];
        end
      end
    end
  end
endmodule

module tk_checker #(
  parameter int ADDR_W     = 19,
  parameter int RST_CYCLES = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              sel,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic              pwr_ok,
  input logic              bank_hit,
  input logic              irq,
  input logic              wd_rst,
  input logic [7:0]        flag_bits,
  input logic [7:0]        ctrl_q,
  input logic [7:0]        wd_set_q,
  input logic [7:0]        live_sec,
  input logic              hold_q,
  input logic              load_p
);
  localparam int RC_W = $clog2(RST_CYCLES + 2);
  logic [RC_W-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) hi_cnt <= '0;
    else if (wd_rst) hi_cnt <= (hi_cnt > RC_W'(RST_CYCLES)) ? hi_cnt : hi_cnt + 1'b1;
    else hi_cnt <= '0;
  end

  p_hit_r1: assert property (@(posedge clk) disable iff (rst)
    bank_hit |-> $past(sel && !we && (&addr[ADDR_W-1:4])));

  p_sec_step_r2: assert property (@(posedge clk) disable iff (rst)
    (live_sec != $past(live_sec)) && !$past(load_p)
      |-> (live_sec == 8'h00 || live_sec == tk_pkg::bcd_inc($past(live_sec))));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    $past(hold_q && !load_p) |-> $stable(live_sec));

  p_irq_src_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(flag_bits[7] || flag_bits[6]));

  p_rst_len_r9: assert property (@(posedge clk) disable iff (rst)
    hi_cnt <= RC_W'(RST_CYCLES));

  p_pwr_lock_r10: assert property (@(posedge clk) disable iff (rst)
    !pwr_ok |=> $stable(ctrl_q) && $stable(wd_set_q));
endmodule

bind timekeep_bank tk_checker #(.ADDR_W(ADDR_W), .RST_CYCLES(WD_RST_CYCLES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sel      (sel),
  .we       (we),
  .addr     (addr),
  .pwr_ok   (pwr_ok),
  .bank_hit (bank_hit),
  .irq      (irq),
  .wd_rst   (wd_rst),
  .flag_bits(flag_bits),
  .ctrl_q   (ctrl_q),
  .wd_set_q (wd_set_q),
  .live_sec (now_t.sec),
  .hold_q   (hold_q),
  .load_p   (load_p)
);

// File: tb/test_timekeep_bank.sv
module test_timekeep_bank;
  localparam int AW = 19, UNIT = 16, RSTC = 4;

  logic clk = 1'b0, rst = 1'b1, sel = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata, flag_bits;
  logic bank_hit, sec_tick = 1'b0, pwr_ok = 1'b1, bat_low = 1'b0, wdi = 1'b0, irq, wd_rst;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  int m_s, m_mi, m_h, m_wd, m_d, m_mo, m_y, m_c;

  always #4 clk = ~clk;

  timekeep_bank #(.ADDR_W(AW), .WD_UNIT_CYCLES(UNIT), .WD_RST_CYCLES(RSTC)) i_timekeep_bank (
    .clk(clk), .rst(rst), .sel(sel), .we(we), .addr(addr), .wdata(wdata), .rdata(rdata),
    .bank_hit(bank_hit), .sec_tick(sec_tick), .pwr_ok(pwr_ok), .bat_low(bat_low), .wdi(wdi),
    .irq(irq), .wd_rst(wd_rst), .flag_bits(flag_bits));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] to_bcd(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int days_in(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_tick();
    m_s++;
    if (m_s < 60) return;
    m_s = 0; m_mi++;
    if (m_mi < 60) return;
    m_mi = 0; m_h++;
    if (m_h < 24) return;
    m_h = 0; m_wd = (m_wd == 7) ? 1 : m_wd + 1; m_d++;
    if (m_d <= days_in(m_mo, m_y)) return;
    m_d = 1; m_mo++;
    if (m_mo <= 12) return;
    m_mo = 1; m_y++;
    if (m_y <= 99) return;
    m_y = 0; m_c = (m_c + 1) % 100;
  endtask

  task automatic wr(logic [3:0] off, logic [7:0] d);
    @(negedge clk); sel = 1; we = 1; addr = {{(AW-4){1'b1}}, off}; wdata = d;
    @(negedge clk); sel = 0; we = 0;
  endtask

  task automatic rd_at(logic [AW-1:0] a, output logic [7:0] d, output logic h);
    @(negedge clk); sel = 1; we = 0; addr = a;
    @(negedge clk); sel = 0; d = rdata; h = bank_hit;
  endtask

  task automatic rd(logic [3:0] off, output logic [7:0] d);
    logic h;
    rd_at({{(AW-4){1'b1}}, off}, d, h);
  endtask

  task automatic tick(bit model);
    @(negedge clk); sec_tick = 1;
    @(negedge clk); sec_tick = 0;
    if (model) model_tick();
  endtask

  task automatic load_time(int y, int mo, int d, int wd, int h, int mi, int s, int c);
    m_y = y; m_mo = mo; m_d = d; m_wd = wd; m_h = h; m_mi = mi; m_s = s; m_c = c;
    wr(4'd8, 8'h80);
    wr(4'd9, to_bcd(s)); wr(4'd10, to_bcd(mi)); wr(4'd11, to_bcd(h)); wr(4'd12, to_bcd(wd));
    wr(4'd13, to_bcd(d)); wr(4'd14, to_bcd(mo)); wr(4'd15, to_bcd(y));
    wr(4'd8, 8'h00);
    wr(4'd1, to_bcd(c));
  endtask

  task automatic check_time(string req);
    logic [7:0] v;
    rd(4'd9, v);  check({req, " sec"},   v, to_bcd(m_s));
    rd(4'd10, v); check({req, " min"},   v, to_bcd(m_mi));
    rd(4'd11, v); check({req, " hour"},  v, to_bcd(m_h));
    rd(4'd12, v); check({req, " wday"},  v, to_bcd(m_wd));
    rd(4'd13, v); check({req, " date"},  v, to_bcd(m_d));
    rd(4'd14, v); check({req, " month"}, v, to_bcd(m_mo));
    rd(4'd15, v); check({req, " year"},  v, to_bcd(m_y));
    rd(4'd1, v);  check({req, " cent"},  v, to_bcd(m_c));
  endtask

  // watches wd_rst for a window; reports first high cycle and width
  task automatic watch(int cycles, output int first, output int width, output bit irq_seen);
    first = -1; width = 0; irq_seen = 0;
    for (int i = 1; i <= cycles; i++) begin
      @(negedge clk);
      if (wd_rst) begin if (first < 0) first = i; width++; end
      if (irq) irq_seen = 1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, s0;
    logic h;
    int first, width;
    bit iseen;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst = 0;

    // R11 reset state
    m_y = 0; m_mo = 1; m_d = 1; m_wd = 1; m_h = 0; m_mi = 0; m_s = 0; m_c = 0;
    check_time("R11 reset");
    rd(4'd0, v); check("R11 reset flags", v, 8'h00);
    rd(4'd8, v); check("R11 reset ctrl", v, 8'h00);

    // R1 decode
    rd_at(19'h3FFF9, v, h); check("R1 miss data", v, 8'h00); check("R1 miss hit", h, 1'b0);
    rd_at(19'h7FFF6, v, h); check("R1 hit flag", h, 1'b1);

    // R2 R3 directed rollovers
    load_time(99, 12, 31, 7, 23, 59, 58, 19);
    check_time("R4 load");
    tick(1); tick(1);
    check_time("R3 century roll");
    load_time(24, 2, 28, 3, 23, 59, 59, 20); tick(1); check_time("R3 leap feb");
    load_time(23, 2, 28, 3, 23, 59, 59, 20); tick(1); check_time("R3 plain feb");
    load_time(23, 4, 30, 5, 23, 59, 59, 20); tick(1); check_time("R3 april end");
    load_time(23, 6, 15, 2, 10, 59, 59, 20); tick(1); check_time("R2 hour carry");

    // R2 R3 random, biased toward boundaries
    for (int it = 0; it < 14; it++) begin
      int y, mo, d, hh, mi, s, n;
      y = $urandom_range(0, 99); mo = $urandom_range(1, 12);
      d = ($urandom_range(0, 1) == 1) ? days_in(mo, y) : $urandom_range(1, days_in(mo, y));
      hh = ($urandom_range(0, 1) == 1) ? 23 : $urandom_range(0, 23);
      mi = ($urandom_range(0, 1) == 1) ? 59 : $urandom_range(0, 59);
      s = $urandom_range(55, 59);
      load_time(y, mo, d, $urandom_range(1, 7), hh, mi, s, $urandom_range(0, 99));
      n = $urandom_range(1, 6);
      for (int t = 0; t < n; t++) tick(1);
      check_time("R2 random");
    end

    // R4 writes ignored without hold, ticks lost with hold
    wr(4'd9, 8'h33); rd(4'd9, v); check("R4 ignore write", v, to_bcd(m_s));
    wr(4'd8, 8'h80); tick(0); tick(0);
    rd(4'd9, v); check("R4 hold copy", v, to_bcd(m_s));
    wr(4'd8, 8'h00); check_time("R4 frozen");

    // R5 snapshot
    wr(4'd8, 8'h40); rd(4'd9, s0); check("R5 snap", s0, to_bcd(m_s));
    tick(1); tick(1); tick(1);
    rd(4'd9, v); check("R5 snap held", v, s0);
    wr(4'd8, 8'h00); check_time("R5 after release");

    // R6 R7 alarm
    load_time(23, 12, 5, 2, 10, 20, 30, 20);
    rd(4'd0, v);
    wr(4'd2, 8'h31); wr(4'd3, 8'h80); wr(4'd4, 8'h80); wr(4'd5, 8'h80); wr(4'd6, 8'h80);
    tick(1); repeat (3) @(negedge clk);
    check("R7 irq on alarm", irq, 1'b1);
    check("R7 flag port", flag_bits, 8'h40);
    rd(4'd0, v); check("R6 alarm flag", v, 8'h40);
    rd(4'd0, v); check("R7 cleared by read", v, 8'h00);
    repeat (2) @(negedge clk); check("R7 irq dropped", irq, 1'b0);
    wr(4'd2, 8'h32); wr(4'd6, 8'h11);
    tick(1); repeat (2) @(negedge clk);
    rd(4'd0, v); check("R6 month mismatch", v, 8'h00);
    wr(4'd2, 8'h80); wr(4'd6, 8'h80);
    tick(1); repeat (2) @(negedge clk);
    rd(4'd0, v); check("R6 repeat 1", v, 8'h40);
    tick(1); repeat (2) @(negedge clk);
    rd(4'd0, v); check("R6 repeat 2", v, 8'h40);
    wr(4'd6, 8'h00); wr(4'd2, 8'h00);
    tick(1); repeat (2) @(negedge clk); rd(4'd0, v);

    // R8 R9 watchdog, steering to reset
    wr(4'd7, 8'h02);
    watch(80, first, width, iseen);
    check("R8 expiry time", (first >= 30 && first <= 36), 1'b1);
    check("R9 reset width", width, RSTC);
    check("R9 no irq on reset steer", iseen, 1'b0);
    rd(4'd0, v); check("R9 expired flag", v, 8'h80);

    // R8 kicks keep it quiet
    wr(4'd7, 8'h02);
    first = -1;
    for (int k = 0; k < 12; k++) begin
      int f, w; bit q;
      watch(10, f, w, q);
      if (f >= 0) first = f;
      wdi = ~wdi;
    end
    check("R8 kicked no reset", first, -1);
    watch(60, first, width, iseen);
    check("R8 stop kick expires", first >= 0, 1'b1);
    rd(4'd0, v);

    // R9 steering to interrupt
    wr(4'd7, 8'h81);
    watch(30, first, width, iseen);
    check("R9 irq steer", irq, 1'b1);
    check("R9 irq steer no reset", first, -1);
    rd(4'd0, v); check("R9 irq steer flag", v, 8'h80);
    repeat (2) @(negedge clk); check("R7 irq cleared wd", irq, 1'b0);

    // R8 zero disables
    wr(4'd7, 8'h00);
    watch(100, first, width, iseen);
    check("R8 disabled reset", first, -1);
    check("R8 disabled irq", iseen, 1'b0);

    // R10 power lockout
    pwr_ok = 0;
    wr(4'd8, 8'h80); rd(4'd8, v); check("R10 ctrl locked", v, 8'h00);
    wr(4'd2, 8'h55); rd(4'd2, v); check("R10 alarm locked", v, 8'h00);
    wr(4'd7, 8'h05); rd(4'd7, v); check("R10 wdog locked", v, 8'h00);
    tick(1); rd(4'd9, v); check("R10 time runs", v, to_bcd(m_s));
    pwr_ok = 1;

    // R11 battery flag
    bat_low = 1; repeat (2) @(negedge clk);
    rd(4'd0, v); check("R11 battery flag", v, 8'h10);
    rd(4'd0, v); check("R11 battery not cleared", v, 8'h10);
    bat_low = 0; repeat (2) @(negedge clk);
    check("R11 battery follows", flag_bits, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule